// File: doc/BRIEF.md
# External Bus Yield Arbiter

This block lets an outside master borrow the processor's external memory bus. It watches an asynchronous request line and the processor's own external-access activity. When it hands the bus over, it switches off the drivers for the address bus, the data bus and every memory strobe, and raises a grant output. It gives the bus back when the request is withdrawn. An access that is already running is never cut short. The grant waits only for that access to end, not for the whole instruction. So a grant can fall between the two external accesses of a single instruction.

The core can be handled in two ways while the bus is lent out. With the continue option off, the core is halted for as long as the grant lasts. With it on, the core keeps running and stalls only when it actually has an external access pending. A separate hung output reports that the processor has an access waiting, from the core or from the boot DMA engine, which the grant is holding up. Arbitration keeps working while the core is held in reset or is loading its boot image.

Top module: `bus_yield_arbiter`

## Requirements
- R1: After the block reset, `bus_gnt`, `stall_core` and `bus_hung` are 0, `addr_oe`, `data_oe` and every bit of `strb_oe` are 1, and `acc_allow` is 1.
- R2: `ext_req` passes through `SYNC_STAGES` flops (default 2). With no access in progress, `bus_gnt` rises on the rising edge that follows the first cycle in which the synchronized request is seen. With the default depth, a request set up before edge k is granted at edge k+2.
- R3: While `bus_gnt` is 1, `addr_oe`, `data_oe` and all bits of `strb_oe` are 0. They change on the same edge as `bus_gnt`.
- R4: While `acc_busy` is 1, no grant is given at the next edge. The grant is given at the edge that ends the first cycle in which `acc_busy` is 0 and the synchronized request is 1.
- R5: `acc_allow` is 0 whenever the synchronized request or the grant is active. A second access of the same instruction therefore waits, and the bus is granted between the two accesses.
- R6: With `go_mode` = 0, `stall_core` is 1 exactly while `bus_gnt` is 1.
- R7: With `go_mode` = 1, `stall_core` stays 0 while the bus is granted and the core has no access pending. When `core_acc_req` is 1 during a grant, `stall_core` rises at the next edge.
- R8: `bus_hung` is 1 at an edge that leaves the bus granted while the core (outside reset) or the boot DMA has an access pending. It is never 1 without a grant.
- R9: Once the synchronized request is 0, `bus_gnt`, `bus_hung` and `stall_core` fall and all output enables return to 1 on the same edge. `acc_allow` is 1 in that cycle, so a pending access starts no earlier than the next edge.
- R10: While `cpu_rst` = 1, requests are still granted and released as usual. `core_acc_req` is disregarded for `bus_hung` and `stall_core`, while `dma_acc_req` still raises `bus_hung`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously inside |
| ext_req | input | 1 | Bus request from the outside master, asynchronous, active high |
| go_mode | input | 1 | 1: core keeps running during a grant until it needs the bus |
| cpu_rst | input | 1 | Core is held in reset (core access requests disregarded) |
| core_acc_req | input | 1 | Core has an external access waiting to start |
| dma_acc_req | input | 1 | Boot DMA engine has an external access waiting to start |
| acc_busy | input | 1 | An external access is in progress this cycle |
| bus_gnt | output | 1 | Bus granted to the outside master |
| addr_oe | output | 1 | Address bus driver enable |
| data_oe | output | 1 | Data bus driver enable |
| strb_oe | output | N_STROBES | Driver enables for memory selects and read/write strobes |
| acc_allow | output | 1 | A new external access may start at the next edge |
| stall_core | output | 1 | Holds the core pipeline |
| bus_hung | output | 1 | An access is pending but blocked by the grant |

## Verification
The assertions assume the memory sequencer obeys the block. `acc_busy` rises only at an edge that ends a cycle with `acc_allow` high, so it is never 1 while the bus is granted. Pending access requests stay asserted until they are served. The bench plays the sequencer itself. It raises `acc_busy` only in cycles where it has just seen `acc_allow` high, or before any request has reached the synchronizer, and it holds `core_acc_req` and `dma_acc_req` steady across each grant. Every input changes on the falling edge, so the synchronized request and the access flag are settled at every rising edge.

// File: rtl/bya_pkg.sv
package bya_pkg;
  // Ownership of the external bus
  typedef enum logic [0:0] {
    BUS_OWNED   = 1'b0,
    BUS_YIELDED = 1'b1
  } bus_state_e;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_STROBES     = 6;
endpackage

// File: rtl/bya_rst_sync.sv
module bya_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned MSB = STAGES - 1;

  logic [MSB:0] chain_q;
  logic [MSB:0] chain_d;

  always_comb begin
    chain_d = {chain_q[MSB-1:0], 1'b1};
  end

  // asserts at once, releases after STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[MSB];
endmodule

// File: rtl/bya_req_sync.sv
module bya_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  localparam int unsigned MSB = STAGES - 1;

  logic [MSB:0] sh_q;
  logic [MSB:0] sh_d;

  always_comb begin
    sh_d = {sh_q[MSB-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sync_out = sh_q[MSB];
endmodule

// File: rtl/bya_grant_fsm.sv
module bya_grant_fsm
  import bya_pkg::*;
#(
  parameter int unsigned N_STROBES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_s,
  input  logic                 acc_busy,
  output logic                 gnt_next,
  output logic                 bus_gnt,
  output logic                 addr_oe,
  output logic                 data_oe,
  output logic [N_STROBES-1:0] strb_oe,
  output logic                 acc_allow
);
  bus_state_e state_q, state_d;
  logic       state_en;
  logic       gnt_q, gnt_d, gnt_en;
  logic       oe_d;

  // next state: yield only between accesses, reclaim on release
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BUS_OWNED:   if (req_s && !acc_busy) state_d = BUS_YIELDED;
      BUS_YIELDED: if (!req_s)             state_d = BUS_OWNED;
      default:                             state_d = BUS_OWNED;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= BUS_OWNED;
    else if (state_en) state_q <= state_d;
  end

  always_comb begin
    gnt_d  = (state_d == BUS_YIELDED);
    gnt_en = (gnt_d != gnt_q);
    oe_d   = ~gnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gnt_q <= 1'b0;
    else if (gnt_en) gnt_q <= gnt_d;
  end

  // one flop per driver enable, all switching with the grant flop
  logic addr_oe_q, data_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_oe_q <= 1'b1;
      data_oe_q <= 1'b1;
    end else if (gnt_en) begin
      addr_oe_q <= oe_d;
      data_oe_q <= oe_d;
    end
  end

  for (genvar g = 0; g < N_STROBES; g++) begin : g_strb_oe
    logic oe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      oe_q <= 1'b1;
      else if (gnt_en) oe_q <= oe_d;
    end
    assign strb_oe[g] = oe_q;
  end

  assign gnt_next  = gnt_d;
  assign bus_gnt   = gnt_q;
  assign addr_oe   = addr_oe_q;
  assign data_oe   = data_oe_q;
  assign acc_allow = !req_s && (state_q == BUS_OWNED);
endmodule

// File: rtl/bya_hold_ctrl.sv
module bya_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt_next,
  input  logic go_mode,
  input  logic cpu_rst,
  input  logic core_acc_req,
  input  logic dma_acc_req,
  output logic stall_core,
  output logic bus_hung
);
  logic core_need;
  logic stall_q, stall_d, stall_en;
  logic hung_q, hung_d, hung_en;

  always_comb begin
    core_need = core_acc_req && !cpu_rst;
    stall_d   = gnt_next && (!go_mode || core_need);
    hung_d    = gnt_next && (core_need || dma_acc_req);
    stall_en  = (stall_d != stall_q);
    hung_en   = (hung_d != hung_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stall_q <= 1'b0;
    else if (stall_en) stall_q <= stall_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hung_q <= 1'b0;
    else if (hung_en) hung_q <= hung_d;
  end

  assign stall_core = stall_q;
  assign bus_hung   = hung_q;
endmodule

// File: rtl/bus_yield_arbiter.sv
module bus_yield_arbiter
  import bya_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned N_STROBES   = DEF_STROBES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_req,
  input  logic                 go_mode,
  input  logic                 cpu_rst,
  input  logic                 core_acc_req,
  input  logic                 dma_acc_req,
  input  logic                 acc_busy,
  output logic                 bus_gnt,
  output logic                 addr_oe,
  output logic                 data_oe,
  output logic [N_STROBES-1:0] strb_oe,
  output logic                 acc_allow,
  output logic                 stall_core,
  output logic                 bus_hung
);
  logic rst_core_n;
  logic req_s;
  logic gnt_next;

  bya_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  bya_req_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (ext_req),
    .sync_out (req_s)
  );

  bya_grant_fsm #(.N_STROBES(N_STROBES)) i_grant (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_s     (req_s),
    .acc_busy  (acc_busy),
    .gnt_next  (gnt_next),
    .bus_gnt   (bus_gnt),
    .addr_oe   (addr_oe),
    .data_oe   (data_oe),
    .strb_oe   (strb_oe),
    .acc_allow (acc_allow)
  );

  bya_hold_ctrl i_hold (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .gnt_next     (gnt_next),
    .go_mode      (go_mode),
    .cpu_rst      (cpu_rst),
    .core_acc_req (core_acc_req),
    .dma_acc_req  (dma_acc_req),
    .stall_core   (stall_core),
    .bus_hung     (bus_hung)
  );
endmodule

// File: rtl/bya_checker.sv
module bya_checker #(
  parameter int unsigned N_STROBES = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_s,
  input logic                 go_mode,
  input logic                 cpu_rst,
  input logic                 core_acc_req,
  input logic                 dma_acc_req,
  input logic                 acc_busy,
  input logic                 bus_gnt,
  input logic                 addr_oe,
  input logic                 data_oe,
  input logic [N_STROBES-1:0] strb_oe,
  input logic                 acc_allow,
  input logic                 stall_core,
  input logic                 bus_hung
);
  AST_GRANT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_gnt && req_s && !acc_busy) |=> bus_gnt); // R2

  AST_DRIVERS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> (!addr_oe && !data_oe && (strb_oe == '0))); // R3

  AST_DRIVERS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_gnt |-> (addr_oe && data_oe && (strb_oe == '1))); // R3

  AST_WAIT_FOR_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_gnt && acc_busy) |=> !bus_gnt); // R4

  AST_ACCESS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_gnt) |-> !$past(acc_allow)); // R5

  AST_HALT_WHILE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(go_mode) |-> (stall_core == bus_gnt)); // R6

  AST_GO_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(go_mode) && !$past(core_acc_req)) |-> !stall_core); // R7

  AST_HUNG_ONLY_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hung |-> bus_gnt); // R8

  AST_RELEASE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && !req_s) |=> (!bus_gnt && !bus_hung && !stall_core && addr_oe && acc_allow)); // R9

  AST_RESET_CORE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_rst) && !$past(dma_acc_req)) |-> !bus_hung); // R10
endmodule

bind bus_yield_arbiter bya_checker #(.N_STROBES(N_STROBES)) i_bya_checker (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .req_s        (req_s),
  .go_mode      (go_mode),
  .cpu_rst      (cpu_rst),
  .core_acc_req (core_acc_req),
  .dma_acc_req  (dma_acc_req),
  .acc_busy     (acc_busy),
  .bus_gnt      (bus_gnt),
  .addr_oe      (addr_oe),
  .data_oe      (data_oe),
  .strb_oe      (strb_oe),
  .acc_allow    (acc_allow),
  .stall_core   (stall_core),
  .bus_hung     (bus_hung)
);

// File: tb/test_bus_yield_arbiter.sv
`timescale 1ns/1ps
module test_bus_yield_arbiter;
  localparam int unsigned NS = 6;

  logic clk = 1'b0;
  logic rst_n, ext_req, go_mode, cpu_rst, core_acc_req, dma_acc_req, acc_busy;
  logic bus_gnt, addr_oe, data_oe, acc_allow, stall_core, bus_hung;
  logic [NS-1:0] strb_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  bus_yield_arbiter #(.N_STROBES(NS)) i_bus_yield_arbiter (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .go_mode(go_mode),
    .cpu_rst(cpu_rst), .core_acc_req(core_acc_req), .dma_acc_req(dma_acc_req),
    .acc_busy(acc_busy), .bus_gnt(bus_gnt), .addr_oe(addr_oe),
    .data_oe(data_oe), .strb_oe(strb_oe), .acc_allow(acc_allow),
    .stall_core(stall_core), .bus_hung(bus_hung)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one rising edge, then settle on the falling edge
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk_granted(input string req, input logic g);
    chk(req, "bus_gnt", bus_gnt, g);
    chk(req, "addr_oe", addr_oe, !g);
    chk(req, "data_oe", data_oe, !g);
    chk(req, "strb_oe", strb_oe, g ? '0 : {NS{1'b1}});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ext_req = 0; go_mode = 0; cpu_rst = 0;
    core_acc_req = 0; dma_acc_req = 0; acc_busy = 0;
    tick(3);
    chk_granted("R1", 1'b0);
    chk("R1", "stall", stall_core, 0);
    chk("R1", "hung", bus_hung, 0);
    chk("R1", "allow", acc_allow, 1);
    rst_n = 1'b1;
    tick(4);
    chk_granted("R1", 1'b0);
  endtask

  task automatic t_idle_grant;
    ext_req = 1;
    tick(2);
    chk("R2", "no grant before sync", bus_gnt, 0);
    chk("R5", "allow blocked by synced request", acc_allow, 0);
    tick(1);
    chk_granted("R3", 1'b1);
    chk("R6", "halt with go off", stall_core, 1);
    chk("R8", "no hung without pending", bus_hung, 0);
    ext_req = 0;
    tick(2);
    chk("R9", "still granted in sync", bus_gnt, 1);
    tick(1);
    chk_granted("R9", 1'b0);
    chk("R9", "stall released", stall_core, 0);
    chk("R9", "allow back", acc_allow, 1);
  endtask

  task automatic t_defer_busy;
    acc_busy = 1;  // access started while allow was high
    ext_req  = 1;
    tick(5);
    chk("R4", "deferred while busy", bus_gnt, 0);
    acc_busy = 0;
    tick(1);
    chk_granted("R4", 1'b1);
    ext_req = 0;
    tick(3);
    chk("R9", "released", bus_gnt, 0);
  endtask

  task automatic t_two_access;
    acc_busy = 1;  // first access of the instruction
    ext_req  = 1;
    tick(3);
    acc_busy = 0;
    core_acc_req = 1; // second access waiting
    chk("R5", "second access held", acc_allow, 0);
    tick(1);
    chk("R5", "granted between accesses", bus_gnt, 1);
    chk("R8", "hung with core pending", bus_hung, 1);
    chk("R6", "stall", stall_core, 1);
    tick(2);
    chk("R5", "still held", acc_allow, 0);
    ext_req = 0;
    tick(3);
    chk("R9", "grant drops", bus_gnt, 0);
    chk("R9", "hung drops", bus_hung, 0);
    chk("R9", "allow for pending", acc_allow, 1);
    chk("R9", "addr driven", addr_oe, 1);
    core_acc_req = 0; acc_busy = 1;
    tick(1);
    acc_busy = 0;
    tick(1);
  endtask

  task automatic t_go_mode;
    go_mode = 1;
    ext_req = 1;
    tick(3);
    chk("R7", "granted", bus_gnt, 1);
    chk("R7", "core runs", stall_core, 0);
    chk("R8", "not hung", bus_hung, 0);
    core_acc_req = 1;
    tick(1);
    chk("R7", "stall on need", stall_core, 1);
    chk("R8", "hung on need", bus_hung, 1);
    ext_req = 0;
    tick(3);
    chk("R9", "stall released", stall_core, 0);
    chk("R9", "hung released", bus_hung, 0);
    chk("R9", "grant released", bus_gnt, 0);
    core_acc_req = 0; acc_busy = 1;
    tick(1);
    acc_busy = 0; go_mode = 0;
    tick(1);
  endtask

  task automatic t_cpu_reset;
    cpu_rst = 1; core_acc_req = 1; go_mode = 1;
    ext_req = 1;
    tick(3);
    chk_granted("R10", 1'b1);
    chk("R10", "core req disregarded hung", bus_hung, 0);
    chk("R10", "core req disregarded stall", stall_core, 0);
    dma_acc_req = 1;
    tick(1);
    chk("R10", "boot dma hung", bus_hung, 1);
    ext_req = 0;
    tick(3);
    chk("R10", "release in reset", bus_gnt, 0);
    chk("R8", "hung off", bus_hung, 0);
    dma_acc_req = 0; core_acc_req = 0; cpu_rst = 0; go_mode = 0;
    tick(1);
  endtask

  task automatic t_dma_go_off;
    dma_acc_req = 1;
    ext_req = 1;
    tick(3);
    chk("R8", "dma hung", bus_hung, 1);
    chk("R6", "halt", stall_core, 1);
    ext_req = 0;
    tick(3);
    chk("R8", "dma hung cleared", bus_hung, 0);
    dma_acc_req = 0;
    tick(1);
  endtask

  initial begin
    t_reset();
    t_idle_grant();
    t_defer_busy();
    t_two_access();
    t_go_mode();
    t_cpu_reset();
    t_dma_go_off();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule